// File: doc/BRIEF.md
# Dual-Bank Flash Command Sequencer

This block sits between a byte-wide host bus and a modelled two-bank flash array. The host writes single bytes as commands, and the block decodes them into byte programming, paired-byte programming, block erase, erase suspend and resume, protection and lock commands. Each bank has its own enable line, its own sequencer, its own busy interlock and its own status byte. One bank can therefore be erasing while the host reads array data from the other bank. Array timing is modelled by a countdown of `WRITE_CYCLES` or `ERASE_CYCLES` clocks.

Each bank contains 2^`BLK_W` erase blocks of 2^`OFFS_W` bytes. The address is split into a block index in the upper `BLK_W` bits and an offset in the lower `OFFS_W` bits. A production build uses 16 blocks of 16,384 bytes per bank. The default parameters shrink each block so that the model stays small.

Each block has a lock bit. After reset, a bank treats every block as locked until the host arms that bank with a protect sequence. Once a bank is armed, only the blocks whose lock bit is set are refused. A read returns either the status byte or array data, depending on the read mode of the selected bank. Read data appears one clock after the read strobe.

Top module: `dbflash_ctl`

## Requirements
- R1: After reset, every array byte reads 0xFF. Each bank starts in array-read mode, and its status byte reads 0x80. Status bit 7 is ready, bit 6 is erase-suspended, bit 5 is erase error, bit 4 is write error, and bits 3..0 read 0.
- R2: Byte program is command 0x40 followed by a data cycle at the target address. The bank is busy for exactly `WRITE_CYCLES` clocks after the data cycle. Programming stores the bitwise AND of the old byte and the new byte.
- R3: Paired program is command 0xE0, then a first data cycle carrying the address and the low byte, then a second data cycle carrying the high byte. The high byte goes to the next offset. The offset wraps to 0 inside the same block. Both bytes complete in one `WRITE_CYCLES` operation.
- R4: Block erase is command 0x20 followed by 0xD0 at any address inside the block. The bank is busy for `ERASE_CYCLES` clocks, after which every byte of that block reads 0xFF.
- R5: Until command 0x60 followed by 0x01 has been written to a bank, every program or erase aimed at that bank is refused. A refused program sets bit 4, a refused erase sets bit 5, and the array is left unchanged. Arming one bank leaves the other bank locked.
- R6: Command 0x60 followed by 0xF1 sets the lock bit of the addressed block. Command 0x60 followed by 0xD0 clears it. In an armed bank, a program or erase aimed at a locked block is refused as in R5, and an unlocked block is accepted.
- R7: While a bank is busy, every write to it is ignored except 0x70, and except 0xB0 during an erase. Busy is status bit 7 = 0.
- R8: Writing 0xB0 during an erase suspends it. Status then reads bit 6 = 1 and bit 7 = 1, and the erase countdown is frozen. Array reads return the current contents. Writing 0xD0 resumes the erase, which then finishes with its remaining count.
- R9: A bank serves array reads while the other bank is busy erasing.
- R10: Two cases set both error bits and return the bank to array-read mode: an unknown command in the idle state, and a setup command followed by a wrong confirm code. Error bits stay set until command 0x50.
- R11: Command 0x70 selects status reads and 0xFF selects array reads. Launching or refusing a program or erase switches the bank to status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bank_en | input | NUM_BANKS | One enable per bank, one-hot for a bus cycle |
| wr_en | input | 1 | Command or data write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | BLK_W+OFFS_W | Block index (upper bits) and byte offset (lower bits) |
| wdata | input | 8 | Command or data byte |
| rdata | output | 8 | Read result, one clock after `rd_en` |

## Verification
Timing:
- A write strobed at edge D changes the bank state at D. A program completes at edge D+`WRITE_CYCLES`, and an erase completes at edge D+`ERASE_CYCLES`.
- `rdata` is registered, so a read strobed at edge R shows the state left by edge R-1.

How the bench uses this:
- After each launch, the bench reads status back-to-back and counts the reads until bit 7 rises. It expects exactly `WRITE_CYCLES`+1 reads for a program and `ERASE_CYCLES`+1 reads for an erase.
- Inputs are driven at the falling edge and outputs are sampled at the next falling edge, one register stage after the strobe.
- For suspend, the bank is left idle for longer than a full erase, and the bench then checks that the status byte has not moved.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
   localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
   localparam logic [7:0] CMD_READ_STATUS = 8'h70;
   localparam logic [7:0] CMD_CLEAR_STAT  = 8'h50;
   localparam logic [7:0] CMD_PROG        = 8'h40;
   localparam logic [7:0] CMD_PROG_PAIR   = 8'hE0;
   localparam logic [7:0] CMD_ERASE       = 8'h20;
   localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
   localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
   localparam logic [7:0] CMD_PROTECT     = 8'h60;
   localparam logic [7:0] CMD_ARM         = 8'h01;
   localparam logic [7:0] CMD_LOCK_BLK    = 8'hF1;

   // flag nibble: [3] ready, [2] suspended, [1] erase error, [0] write error
   localparam int FL_READY = 3;
   localparam int FL_SUSP  = 2;
   localparam int FL_EERR  = 1;
   localparam int FL_WERR  = 0;

   typedef enum logic [3:0] {
      ST_IDLE, ST_PROG_DATA, ST_PAIR_LO, ST_PAIR_HI, ST_ERASE_CONF,
      ST_PROT_CONF, ST_BUSY_PROG, ST_BUSY_ERASE, ST_SUSPENDED
   } seq_state_e;
endpackage

// File: rtl/dbf_op_timer.sv
module dbf_op_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   output logic          expire
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expire = run && (cnt == '0);
endmodule

// File: rtl/dbf_bank_seq.sv
module dbf_bank_seq
   import dbf_pkg::*;
#(
   parameter int BLK_W        = 4,
   parameter int OFFS_W       = 4,
   parameter int WRITE_CYCLES = 4,
   parameter int ERASE_CYCLES = 12,
   localparam int AW = BLK_W + OFFS_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_we,
   input  logic [AW-1:0] cmd_addr,
   input  logic [7:0]    cmd_data,
   output logic [3:0]    flags,
   output logic          show_status,
   output logic          prog_go,
   output logic          erase_go,
   output logic          pair,
   output logic [AW-1:0] op_addr,
   output logic [7:0]    lo_byte,
   output logic [7:0]    hi_byte
);
   localparam int NBLK = 1 << BLK_W;
   localparam int MAXC = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);

   seq_state_e state;
   logic err_e, err_w, armed;
   logic [NBLK-1:0] lock_q;
   logic blk_locked, pair_locked, launch_prog, launch_erase, t_run, t_exp;
   logic [CW-1:0] t_val;
   logic [BLK_W-1:0] cmd_blk;

   assign cmd_blk     = cmd_addr[AW-1:OFFS_W];
   assign blk_locked  = !armed || lock_q[cmd_blk];
   assign pair_locked = !armed || lock_q[op_addr[AW-1:OFFS_W]];

   assign launch_prog  = cmd_we && ((state == ST_PROG_DATA && !blk_locked) ||
                                    (state == ST_PAIR_HI && !pair_locked));
   assign launch_erase = cmd_we && state == ST_ERASE_CONF && cmd_data == CMD_CONFIRM && !blk_locked;
   assign t_val = launch_erase ? CW'(ERASE_CYCLES - 1) : CW'(WRITE_CYCLES - 1);
   assign t_run = (state == ST_BUSY_PROG) || (state == ST_BUSY_ERASE);

   dbf_op_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(launch_prog | launch_erase),
      .load_val(t_val), .run(t_run), .expire(t_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;  show_status <= 1'b0;
         err_e <= 1'b0;     err_w <= 1'b0;   armed <= 1'b0;
         lock_q <= '0;      op_addr <= '0;
         lo_byte <= '0;     hi_byte <= '0;   pair <= 1'b0;
      end else begin
         case (state)
            ST_BUSY_PROG: begin
               if (t_exp) state <= ST_IDLE;
               if (cmd_we && cmd_data == CMD_READ_STATUS) show_status <= 1'b1;
            end
            ST_BUSY_ERASE: begin
               if (t_exp) state <= ST_IDLE;
               else if (cmd_we && cmd_data == CMD_SUSPEND) state <= ST_SUSPENDED;
               if (cmd_we && cmd_data == CMD_READ_STATUS) show_status <= 1'b1;
            end
            default: if (cmd_we) begin
               case (state)
                  ST_IDLE: begin
                     case (cmd_data)
                        CMD_READ_ARRAY:  show_status <= 1'b0;
                        CMD_READ_STATUS: show_status <= 1'b1;
                        CMD_CLEAR_STAT:  begin err_e <= 1'b0; err_w <= 1'b0; end
                        CMD_PROG:        state <= ST_PROG_DATA;
                        CMD_PROG_PAIR:   state <= ST_PAIR_LO;
                        CMD_ERASE:       state <= ST_ERASE_CONF;
                        CMD_PROTECT:     state <= ST_PROT_CONF;
                        default: begin err_e <= 1'b1; err_w <= 1'b1; show_status <= 1'b0; end
                     endcase
                  end
                  ST_PROG_DATA: begin
                     show_status <= 1'b1; op_addr <= cmd_addr;
                     lo_byte <= cmd_data; pair <= 1'b0;
                     if (blk_locked) begin err_w <= 1'b1; state <= ST_IDLE; end
                     else state <= ST_BUSY_PROG;
                  end
                  ST_PAIR_LO: begin
                     op_addr <= cmd_addr; lo_byte <= cmd_data; state <= ST_PAIR_HI;
                  end
                  ST_PAIR_HI: begin
                     show_status <= 1'b1; hi_byte <= cmd_data; pair <= 1'b1;
                     if (pair_locked) begin err_w <= 1'b1; state <= ST_IDLE; end
                     else state <= ST_BUSY_PROG;
                  end
                  ST_ERASE_CONF: begin
                     if (cmd_data == CMD_CONFIRM) begin
                        show_status <= 1'b1; op_addr <= cmd_addr;
                        if (blk_locked) begin err_e <= 1'b1; state <= ST_IDLE; end
                        else state <= ST_BUSY_ERASE;
                     end else begin
                        err_e <= 1'b1; err_w <= 1'b1; show_status <= 1'b0; state <= ST_IDLE;
                     end
                  end
                  ST_PROT_CONF: begin
                     state <= ST_IDLE; show_status <= 1'b1;
                     case (cmd_data)
                        CMD_ARM:      armed <= 1'b1;
                        CMD_LOCK_BLK: lock_q[cmd_blk] <= 1'b1;
                        CMD_CONFIRM:  lock_q[cmd_blk] <= 1'b0;
                        default: begin err_e <= 1'b1; err_w <= 1'b1; show_status <= 1'b0; end
                     endcase
                  end
                  ST_SUSPENDED: begin
                     case (cmd_data)
                        CMD_READ_ARRAY:  show_status <= 1'b0;
                        CMD_READ_STATUS: show_status <= 1'b1;
                        CMD_CLEAR_STAT:  begin err_e <= 1'b0; err_w <= 1'b0; end
                        CMD_CONFIRM:     begin state <= ST_BUSY_ERASE; show_status <= 1'b1; end
                        default: ;
                     endcase
                  end
                  default: state <= ST_IDLE;
               endcase
            end
         endcase
      end
   end

   assign prog_go  = t_exp && (state == ST_BUSY_PROG);
   assign erase_go = t_exp && (state == ST_BUSY_ERASE);
   assign flags = {!t_run, state == ST_SUSPENDED, err_e, err_w};
endmodule

// File: rtl/dbf_flash_array.sv
module dbf_flash_array #(
   parameter int NUM_BANKS = 2,
   parameter int BLK_W     = 4,
   parameter int OFFS_W    = 4,
   parameter int PROG_AND  = 1,
   localparam int AW    = BLK_W + OFFS_W,
   localparam int DEPTH = 1 << AW,
   localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_BANKS-1:0]          prog_go,
   input  logic [NUM_BANKS-1:0]          erase_go,
   input  logic [NUM_BANKS-1:0]          pair,
   input  logic [NUM_BANKS-1:0][AW-1:0]  op_addr,
   input  logic [NUM_BANKS-1:0][7:0]     lo_byte,
   input  logic [NUM_BANKS-1:0][7:0]     hi_byte,
   input  logic [SEL_W-1:0]              rd_bank,
   input  logic [AW-1:0]                 rd_addr,
   output logic [7:0]                    rd_byte
);
   logic [NUM_BANKS-1:0][7:0] bank_byte;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [7:0]    mem [DEPTH];
      logic [AW-1:0] a_lo, a_hi;
      logic [7:0]    lo_new, hi_new;

      assign a_lo = op_addr[b];
      assign a_hi = {op_addr[b][AW-1:OFFS_W], op_addr[b][OFFS_W-1:0] + 1'b1};

      if (PROG_AND != 0) begin : g_clear_only
         assign lo_new = mem[a_lo] & lo_byte[b];
         assign hi_new = mem[a_hi] & hi_byte[b];
      end else begin : g_overwrite
         assign lo_new = lo_byte[b];
         assign hi_new = hi_byte[b];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
         end else if (erase_go[b]) begin
            for (int i = 0; i < (1 << OFFS_W); i++)
               mem[{a_lo[AW-1:OFFS_W], OFFS_W'(i)}] <= 8'hFF;
         end else if (prog_go[b]) begin
            mem[a_lo] <= lo_new;
            if (pair[b]) mem[a_hi] <= hi_new;
         end
      end

      assign bank_byte[b] = mem[rd_addr];
   end

   assign rd_byte = bank_byte[rd_bank];
endmodule

// File: rtl/dbflash_ctl.sv
module dbflash_ctl #(
   parameter int NUM_BANKS    = 2,
   parameter int BLK_W        = 4,
   parameter int OFFS_W       = 4,
   parameter int WRITE_CYCLES = 4,
   parameter int ERASE_CYCLES = 12,
   parameter int PROG_AND     = 1,
   localparam int AW    = BLK_W + OFFS_W,
   localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_en,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [AW-1:0]        addr,
   input  logic [7:0]           wdata,
   output logic [7:0]           rdata
);
   if (NUM_BANKS < 1)    begin : g_bad_banks  $error("NUM_BANKS must be at least 1"); end
   if (BLK_W < 1)        begin : g_bad_blk    $error("BLK_W must be at least 1"); end
   if (OFFS_W < 1)       begin : g_bad_offs   $error("OFFS_W must be at least 1"); end
   if (WRITE_CYCLES < 1) begin : g_bad_wcyc   $error("WRITE_CYCLES must be at least 1"); end
   if (ERASE_CYCLES < 1) begin : g_bad_ecyc   $error("ERASE_CYCLES must be at least 1"); end

   logic [NUM_BANKS-1:0][3:0]    bank_flags;
   logic [NUM_BANKS-1:0]         show_stat, prog_go, erase_go, pair;
   logic [NUM_BANKS-1:0][AW-1:0] op_addr;
   logic [NUM_BANKS-1:0][7:0]    lo_byte, hi_byte;
   logic [SEL_W-1:0]             rd_sel;
   logic [7:0]                   arr_byte;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_seq
      dbf_bank_seq #(
         .BLK_W(BLK_W), .OFFS_W(OFFS_W),
         .WRITE_CYCLES(WRITE_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
      ) u_seq (
         .clk(clk), .rst_n(rst_n), .cmd_we(wr_en && bank_en[b]),
         .cmd_addr(addr), .cmd_data(wdata),
         .flags(bank_flags[b]), .show_status(show_stat[b]),
         .prog_go(prog_go[b]), .erase_go(erase_go[b]), .pair(pair[b]),
         .op_addr(op_addr[b]), .lo_byte(lo_byte[b]), .hi_byte(hi_byte[b])
      );
   end

   always_comb begin
      rd_sel = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--)
         if (bank_en[i]) rd_sel = SEL_W'(i);
   end

   dbf_flash_array #(
      .NUM_BANKS(NUM_BANKS), .BLK_W(BLK_W), .OFFS_W(OFFS_W), .PROG_AND(PROG_AND)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .prog_go(prog_go), .erase_go(erase_go),
      .pair(pair), .op_addr(op_addr), .lo_byte(lo_byte), .hi_byte(hi_byte),
      .rd_bank(rd_sel), .rd_addr(addr), .rd_byte(arr_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= show_stat[rd_sel] ? {bank_flags[rd_sel], 4'b0000} : arr_byte;
   end
endmodule

// File: rtl/dbf_ctl_chk.sv
module dbf_ctl_chk
   import dbf_pkg::*;
#(
   parameter int NUM_BANKS = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_en,
   input logic [NUM_BANKS-1:0]      bank_en,
   input logic [7:0]                wdata,
   input logic [NUM_BANKS-1:0][3:0] bank_flags
);
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      // R10
      err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(bank_flags[b][FL_EERR]) &&
          !$past(wr_en && bank_en[b] && wdata == CMD_CLEAR_STAT)) |-> bank_flags[b][FL_EERR]);

      // R8
      susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bank_flags[b][FL_SUSP] |-> bank_flags[b][FL_READY]);

      // R7
      busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(bank_flags[b][FL_READY]) |-> $past(wr_en && bank_en[b]));

      // R5
      werr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(bank_flags[b][FL_WERR]) |-> $past(wr_en && bank_en[b]));

      // R6
      eerr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(bank_flags[b][FL_EERR]) |-> $past(wr_en && bank_en[b]));
   end
endmodule

bind dbflash_ctl dbf_ctl_chk #(.NUM_BANKS(NUM_BANKS)) u_ctl_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bank_en(bank_en),
   .wdata(wdata), .bank_flags(bank_flags)
);

// File: tb/tb_dbflash_ctl.sv
module tb_dbflash_ctl;
   localparam int WC = 4;
   localparam int EC = 12;
   localparam int NV = 28;

   // entry: {req[7:0], kind[3:0] (1 = read), bank[3:0], addr[7:0], data[7:0], expect[7:0]}
   localparam logic [39:0] VEC [NV] = '{
      40'h01_1_0_00_00_FF,   // R1 array reads erased
      40'h01_1_1_35_00_FF,   // R1
      40'h0B_0_0_00_70_00,   // R11 status mode
      40'h01_1_0_00_00_80,   // R1 status after reset
      40'h0B_0_1_00_70_00,
      40'h01_1_1_00_00_80,   // R1
      40'h05_0_0_00_40_00,   // R5 program before arming
      40'h05_0_0_12_55_00,
      40'h05_1_0_00_00_90,   // R5 write error
      40'h0A_0_0_00_50_00,
      40'h0A_1_0_00_00_80,   // R10 cleared
      40'h05_0_0_00_20_00,   // R5 erase before arming
      40'h05_0_0_20_D0_00,
      40'h05_1_0_00_00_A0,   // R5 erase error
      40'h0A_0_0_00_50_00,
      40'h0B_0_0_00_FF_00,
      40'h05_1_0_12_00_FF,   // R5 array untouched
      40'h0A_0_1_00_5A_00,   // R10 unknown command
      40'h0A_1_1_00_00_FF,   // R10 back in array mode
      40'h0A_0_1_00_70_00,
      40'h0A_1_1_00_00_B0,   // R10 both error bits
      40'h0A_0_1_00_20_00,   // R10 bad confirm
      40'h0A_0_1_00_FF_00,
      40'h0A_1_1_00_00_FF,   // R10 array mode after bad confirm
      40'h0A_0_1_00_70_00,
      40'h0A_1_1_00_00_B0,   // R10 sticky
      40'h0A_0_1_00_50_00,
      40'h0A_1_1_00_00_80    // R10 cleared by 0x50
   };

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] bank_en;
   logic       wr_en, rd_en;
   logic [7:0] addr, wdata, rdata;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dbflash_ctl #(.WRITE_CYCLES(WC), .ERASE_CYCLES(EC)) dut (
      .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .wr_en(wr_en),
      .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic bwr(input int bank, input logic [7:0] a, input logic [7:0] d);
      bank_en = 2'(1 << bank); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic brd(input int bank, input logic [7:0] a, output logic [7:0] v);
      bank_en = 2'(1 << bank); addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; v = rdata;
   endtask

   task automatic poll_ready(input int bank, output int n);
      logic [7:0] v;
      n = 0;
      do begin brd(bank, 8'h00, v); n++; end while (!v[7] && n < 400);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; bank_en = 2'b01; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual %0d expected below 100000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin : main
      logic [7:0] v;
      int n;
      do_reset();

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [39:0] e;
         e = VEC[i];
         if (e[31:28] == 4'h1) begin
            brd(int'(e[27:24]), e[23:16], v);
            checks++;
            if (v !== e[7:0]) begin
               errors++;
               $display("FAIL R%0d table entry %0d actual %02h expected %02h", e[39:32], i, v, e[7:0]);
            end
         end else begin
            bwr(int'(e[27:24]), e[23:16], e[15:8]);
         end
      end

      // R5: arming bank 0 leaves bank 1 locked
      bwr(0, 8'h00, 8'h60); bwr(0, 8'h00, 8'h01);
      bwr(1, 8'h00, 8'h40); bwr(1, 8'h05, 8'h3C);
      brd(1, 8'h00, v); chk("R5", "bank1 still locked", v, 8'h90);
      bwr(1, 8'h00, 8'h50);
      bwr(1, 8'h00, 8'h60); bwr(1, 8'h00, 8'h01);
      bwr(1, 8'h00, 8'h40); bwr(1, 8'h05, 8'h3C);
      poll_ready(1, n);
      chk("R2", "bank1 program cycles", 8'(n), 8'(WC + 1));

      // R2: byte program timing and AND merge
      bwr(0, 8'h00, 8'h40); bwr(0, 8'h12, 8'h5A);
      poll_ready(0, n);
      chk("R2", "program busy cycles", 8'(n), 8'(WC + 1));
      bwr(0, 8'h00, 8'h40); bwr(0, 8'h12, 8'h0F);
      poll_ready(0, n);
      bwr(0, 8'h00, 8'hFF); brd(0, 8'h12, v);
      chk("R2", "reprogram stores AND", v, 8'h0A);

      // R3: paired program wraps offset within block
      bwr(0, 8'h00, 8'hE0); bwr(0, 8'h2F, 8'h11); bwr(0, 8'h00, 8'h22);
      poll_ready(0, n);
      chk("R3", "pair busy cycles", 8'(n), 8'(WC + 1));
      bwr(0, 8'h00, 8'hFF);
      brd(0, 8'h2F, v); chk("R3", "low byte", v, 8'h11);
      brd(0, 8'h20, v); chk("R3", "high byte wrapped", v, 8'h22);
      brd(0, 8'h30, v); chk("R3", "next block untouched", v, 8'hFF);

      // R7: writes during busy are ignored
      bwr(0, 8'h00, 8'h40); bwr(0, 8'h30, 8'h33);
      bwr(0, 8'h00, 8'h40); bwr(0, 8'h31, 8'h00);
      poll_ready(0, n);
      brd(0, 8'h00, v); chk("R7", "no error after ignored writes", v, 8'h80);
      bwr(0, 8'h00, 8'hFF);
      brd(0, 8'h30, v); chk("R7", "launched program done", v, 8'h33);
      brd(0, 8'h31, v); chk("R7", "ignored data not written", v, 8'hFF);

      // R6: per-block lock bits
      bwr(0, 8'h00, 8'h60); bwr(0, 8'h40, 8'hF1);
      bwr(0, 8'h00, 8'h40); bwr(0, 8'h41, 8'h00);
      brd(0, 8'h00, v); chk("R6", "program to locked block", v, 8'h90);
      bwr(0, 8'h00, 8'h50);
      bwr(0, 8'h00, 8'h20); bwr(0, 8'h40, 8'hD0);
      brd(0, 8'h00, v); chk("R6", "erase of locked block", v, 8'hA0);
      bwr(0, 8'h00, 8'h50);
      bwr(0, 8'h00, 8'h60); bwr(0, 8'h40, 8'hD0);
      bwr(0, 8'h00, 8'h40); bwr(0, 8'h41, 8'h00);
      poll_ready(0, n);
      bwr(0, 8'h00, 8'hFF); brd(0, 8'h41, v);
      chk("R6", "unlocked block accepts program", v, 8'h00);

      // R4: erase timing
      bwr(1, 8'h00, 8'h20); bwr(1, 8'h3A, 8'hD0);
      poll_ready(1, n);
      chk("R4", "erase busy cycles", 8'(n), 8'(EC + 1));

      // R8 and R9: suspend, cross-bank read, resume
      bwr(1, 8'h00, 8'hFF);
      bwr(0, 8'h00, 8'h20); bwr(0, 8'h25, 8'hD0);
      brd(1, 8'h05, v); chk("R9", "other bank array read during erase", v, 8'h3C);
      brd(0, 8'h00, v); chk("R7", "erasing bank busy", v, 8'h00);
      bwr(0, 8'h00, 8'hB0);
      brd(0, 8'h00, v); chk("R8", "suspended status", v, 8'hC0);
      bwr(0, 8'h00, 8'hFF);
      brd(0, 8'h2F, v); chk("R8", "read while suspended", v, 8'h11);
      bwr(0, 8'h00, 8'h70);
      repeat (2 * EC) @(negedge clk);
      brd(0, 8'h00, v); chk("R8", "countdown frozen", v, 8'hC0);
      bwr(0, 8'h00, 8'hD0);
      poll_ready(0, n);
      brd(0, 8'h00, v); chk("R8", "resumed erase completes", v, 8'h80);
      bwr(0, 8'h00, 8'hFF);
      brd(0, 8'h20, v); chk("R4", "erased byte low", v, 8'hFF);
      brd(0, 8'h2F, v); chk("R4", "erased byte high", v, 8'hFF);
      brd(0, 8'h12, v); chk("R4", "other block kept", v, 8'h0A);

      // R1 and R5: reset during an operation
      bwr(1, 8'h00, 8'h20); bwr(1, 8'h05, 8'hD0);
      do_reset();
      brd(1, 8'h05, v); chk("R1", "array mode after reset", v, 8'hFF);
      bwr(1, 8'h00, 8'h70);
      brd(1, 8'h00, v); chk("R1", "status after reset", v, 8'h80);
      bwr(1, 8'h00, 8'h40); bwr(1, 8'h05, 8'h00);
      brd(1, 8'h00, v); chk("R5", "locked again after reset", v, 8'h90);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule